// File: doc/BRIEF.md
# Three-Lane Serial Framer with Optional Balance Slots

This block turns a 21-bit parallel word into three serial bit streams plus a serial copy of the word-rate clock. The word is cut into three 7-bit groups, one per data lane, and each lane sends its group least significant bit first inside a repeating frame. A fourth lane sends a high/low pattern that repeats once per frame, so a receiver can find the frame boundaries and rebuild the word clock.

Two frame formats exist. In the plain format a frame is 7 slots long and carries only data. In the balanced format a frame is 9 slots long: the 7 data bits are followed by two flag bits per lane, which an external encoder supplies to say whether the group was inverted. The clock lane then alternates between frames with 4 and 5 high slots, keeping its running sum near zero. Everything runs on one fast clock. A slot enable input marks each bit time and stands in for a multiplying PLL, so the enable rate sets the bit rate.

Top module: `serial_framer3`

## Requirements
- R1: Lane 0 sends word bits 0-6, lane 1 bits 7-13, lane 2 bits 14-20; within a frame the lowest bit of the group goes in slot 0 and the rest follow in ascending order.
- R2: With `bal_mode` low a frame has 7 slots and the clock lane is high in slots 0-3 and low in slots 4-6.
- R3: With `bal_mode` high a frame has 9 slots; slot 7 of lane L carries `bal_flags[2L]` and slot 8 carries `bal_flags[2L+1]`.
- R4: In balanced frames the clock lane is high in the leading slots and low in the rest, with 4 high slots and 5 high slots in alternating frames; the first balanced frame after reset or after a plain frame has 4 high slots.
- R5: Over a run of consecutive balanced frames, counting +1 per high and -1 per low clock slot from the start of the run, the running sum never exceeds 5 in magnitude.
- R6: `bal_mode` is sampled only when slot 0 of a frame is sent; a change at any other time has no effect on the frame in progress.
- R7: `par_word` and `bal_flags` are captured only in the cycle that sends slot 0, and are sent in the frame that follows; the first frame after reset sends zeros on the data lanes.
- R8: The outputs are registered and change only in cycles where `slot_en` is high; the value for a slot appears after the clock edge at which `slot_en` accepted that slot.
- R9: While `rst` is high at a clock edge all outputs go to 0, and the next accepted slot is slot 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | One-cycle pulse per serial bit time |
| bal_mode | input | 1 | 1 selects 9-slot balanced frames, 0 selects 7-slot plain frames |
| par_word | input | 21 | Parallel data word |
| bal_flags | input | 6 | Two flag bits per lane from the balance encoder |
| lane_out | output | 3 | Serial data, one bit per lane |
| clk_lane | output | 1 | Serial word-rate clock pattern |

## Verification
On every cycle the assertions check that the outputs hold still between slot enables, that the slot counter stays within the frame length of the current format, that the format only switches at a frame head, that the clock lane only rises at a frame head, and that the running sum of the clock lane stays inside its bound. The exact bit in each slot, the alternation of 4-high and 5-high frames, the one-frame delay from capture to transmission and the immunity to mid-frame mode and data changes are shown only by the bench, which compares every output against a queue-based frame model under dense, sparse and irregular slot enables, mode switching and a reset in mid-frame.

// File: rtl/serial_framer3_pkg.sv
package serial_framer3_pkg;
  typedef enum logic {
    FMT_PLAIN = 1'b0,
    FMT_BAL   = 1'b1
  } frame_fmt_e;
endpackage

// File: rtl/sf_slot_timer.sv
module sf_slot_timer
  import serial_framer3_pkg::*;
#(
  parameter int GRP  = 7,
  parameter int FLAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_en,
  input  logic bal_mode,
  output logic frame_head,
  output logic clk_lane
);
  localparam int SLOTS_BAL = GRP + FLAG;
  localparam int CW        = $clog2(SLOTS_BAL + 1);
  localparam int HI_PLAIN  = (GRP + 1) / 2;
  localparam int HI_BAL_A  = SLOTS_BAL / 2;
  localparam int HI_BAL_B  = SLOTS_BAL - HI_BAL_A;
  localparam logic [CW-1:0] LAST_PLAIN = CW'(GRP - 1);
  localparam logic [CW-1:0] LAST_BAL   = CW'(SLOTS_BAL - 1);
  localparam logic [CW-1:0] HI_P  = CW'(HI_PLAIN);
  localparam logic [CW-1:0] HI_A  = CW'(HI_BAL_A);
  localparam logic [CW-1:0] HI_B  = CW'(HI_BAL_B);

  logic [CW-1:0] slot_q;
  frame_fmt_e    fmt_q, fmt_now;
  logic          long_q, long_now;
  logic [CW-1:0] hi_now, last_now;
  logic          clk_q;

  assign frame_head = (slot_q == '0);

  always_comb begin
    if (frame_head) begin
      fmt_now  = frame_fmt_e'(bal_mode);
      long_now = (bal_mode && fmt_q == FMT_BAL) ? ~long_q : 1'b0;
    end else begin
      fmt_now  = fmt_q;
      long_now = long_q;
    end
    if (fmt_now == FMT_BAL) begin
      last_now = LAST_BAL;
      hi_now   = long_now ? HI_B : HI_A;
    end else begin
      last_now = LAST_PLAIN;
      hi_now   = HI_P;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      fmt_q  <= FMT_PLAIN;
      long_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (slot_en) begin
      slot_q <= (slot_q == last_now) ? '0 : slot_q + 1'b1;
      fmt_q  <= fmt_now;
      long_q <= long_now;
      clk_q  <= (slot_q < hi_now);
    end
  end

  assign clk_lane = clk_q;

  // Checker state: running sum of the clock lane over balanced frames.
  logic signed [7:0] dsv_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      dsv_q <= '0;
    end else if (slot_en) begin
      if (fmt_now != FMT_BAL)
        dsv_q <= '0;
      else if (frame_head && fmt_q != FMT_BAL)
        dsv_q <= clk_lane_step(slot_q < hi_now);
      else
        dsv_q <= dsv_q + clk_lane_step(slot_q < hi_now);
    end
  end

  function automatic logic signed [7:0] clk_lane_step(input logic hi);
    return hi ? 8'sd1 : -8'sd1;
  endfunction

  // R5: clock lane running sum stays bounded
  a_r5_clk_dsv: assert property (@(posedge clk) disable iff (rst)
    (dsv_q <= 8'(HI_BAL_B)) && (dsv_q >= -8'(HI_BAL_B)));

  // R2 / R3: the slot index stays inside the current frame length
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot_q <= ((fmt_q == FMT_BAL) ? LAST_BAL : LAST_PLAIN));

  // R6: format only switches when a frame head is sent
  a_r6_fmt_at_head: assert property (@(posedge clk) disable iff (rst)
    !frame_head |=> $stable(fmt_q));
endmodule

// File: rtl/sf_lane.sv
module sf_lane #(
  parameter int GRP  = 7,
  parameter int FLAG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_en,
  input  logic            frame_head,
  input  logic [GRP-1:0]  grp_data,
  input  logic [FLAG-1:0] grp_flags,
  output logic            ser
);
  localparam int W = GRP + FLAG;

  logic [W-1:0] hold_q;
  logic [W-1:0] sh_q;
  logic         ser_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
      ser_q  <= 1'b0;
    end else if (slot_en) begin
      if (frame_head) begin
        ser_q  <= hold_q[0];
        sh_q   <= hold_q >> 1;
        hold_q <= {grp_flags, grp_data};
      end else begin
        ser_q  <= sh_q[0];
        sh_q   <= sh_q >> 1;
      end
    end
  end

  assign ser = ser_q;

  // R8: serial output holds between slot enables
  a_r8_lane_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(ser_q));

  // R9: reset clears the serial output
  a_r9_lane_reset: assert property (@(posedge clk)
    rst |=> (ser_q == 1'b0));
endmodule

// File: rtl/serial_framer3.sv
module serial_framer3
  import serial_framer3_pkg::*;
#(
  parameter int LANES = 3,
  parameter int GRP   = 7,
  parameter int FLAG  = 2,
  localparam int WORD = LANES * GRP,
  localparam int FW   = LANES * FLAG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_en,
  input  logic            bal_mode,
  input  logic [WORD-1:0] par_word,
  input  logic [FW-1:0]   bal_flags,
  output logic [LANES-1:0] lane_out,
  output logic            clk_lane
);
  logic frame_head;

  sf_slot_timer #(.GRP(GRP), .FLAG(FLAG)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .slot_en    (slot_en),
    .bal_mode   (bal_mode),
    .frame_head (frame_head),
    .clk_lane   (clk_lane)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sf_lane #(.GRP(GRP), .FLAG(FLAG)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .slot_en    (slot_en),
      .frame_head (frame_head),
      .grp_data   (par_word[l*GRP +: GRP]),
      .grp_flags  (bal_flags[l*FLAG +: FLAG]),
      .ser        (lane_out[l])
    );
  end

  // R4: the clock lane rises only on the first slot of a frame
  a_r4_clk_rise_head: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lane) |-> $past(frame_head && slot_en));

  // R8: the clock lane holds between slot enables
  a_r8_clk_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(clk_lane));

  // R9: reset clears the clock lane
  a_r9_clk_reset: assert property (@(posedge clk)
    rst |=> (clk_lane == 1'b0));
endmodule

// File: tb/serial_framer3_bench.sv
module serial_framer3_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_en = 1'b0;
  logic        bal_mode = 1'b0;
  logic [20:0] par_word = '0;
  logic [5:0]  bal_flags = '0;
  logic [2:0]  lane_out;
  logic        clk_lane;

  always #5 clk = ~clk;

  serial_framer3 u_serial_framer3 (
    .clk(clk), .rst(rst), .slot_en(slot_en), .bal_mode(bal_mode),
    .par_word(par_word), .bal_flags(bal_flags),
    .lane_out(lane_out), .clk_lane(clk_lane)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase_tag = "R7";

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural frame model
  bit [2:0]  q_lane[$];
  bit        q_clk[$];
  string     q_dtag[$];
  bit        q_head[$];
  logic [20:0] m_word = '0;
  logic [5:0]  m_flag = '0;
  bit        m_prev_bal = 0;
  bit        m_long = 0;
  bit        m_bal = 0;
  bit        m_fresh = 0;
  bit [2:0]  exp_lane = '0;
  bit        exp_clk = 0;
  string     exp_dtag = "R1";
  bit        stepped = 0;
  bit        cur_head = 0;
  int        dsv = 0;

  always @(posedge clk) begin
    stepped = 0;
    if (rst) begin
      q_lane.delete(); q_clk.delete(); q_dtag.delete(); q_head.delete();
      m_word = '0; m_flag = '0; m_prev_bal = 0; m_long = 0; m_bal = 0;
      exp_lane = '0; exp_clk = 0;
    end else if (slot_en) begin
      if (q_clk.size() == 0) begin
        int n, hi;
        m_bal = bal_mode;
        n = m_bal ? 9 : 7;
        if (m_bal) begin
          m_fresh = !m_prev_bal;
          m_long = m_prev_bal ? !m_long : 0;
          hi = m_long ? 5 : 4;
        end else begin
          m_long = 0;
          hi = 4;
        end
        for (int s = 0; s < n; s++) begin
          bit [2:0] v;
          for (int l = 0; l < 3; l++)
            v[l] = (s < 7) ? m_word[l*7 + s] : m_flag[l*2 + (s - 7)];
          q_lane.push_back(v);
          q_clk.push_back(s < hi);
          q_dtag.push_back((s < 7) ? "R1" : "R3");
          q_head.push_back(s == 0);
        end
        m_prev_bal = m_bal;
        m_word = par_word;
        m_flag = bal_flags;
      end
      exp_lane = q_lane.pop_front();
      exp_clk  = q_clk.pop_front();
      exp_dtag = q_dtag.pop_front();
      cur_head = q_head.pop_front();
      stepped = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(lane_out == exp_lane, {exp_dtag, "/", phase_tag, " lane data"},
          int'(lane_out), int'(exp_lane));
      chk(clk_lane == exp_clk, m_bal ? "R4 clock lane" : "R2 clock lane",
          int'(clk_lane), int'(exp_clk));
      if (stepped && m_bal) begin
        if (cur_head && m_fresh) dsv = 0;
        dsv += clk_lane ? 1 : -1;
        chk(dsv <= 5 && dsv >= -5, "R5 clock sum", dsv, 5);
      end
    end
  end

  task automatic run(int n, int en_pct, int mode_sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slot_en   = ($urandom_range(99) < en_pct);
      par_word  = 21'($urandom);
      bal_flags = 6'($urandom);
      if (mode_sel == 2) bal_mode = ($urandom_range(9) == 0) ? ~bal_mode : bal_mode;
      else bal_mode = mode_sel[0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slot_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R9: outputs cleared while reset is held
    chk(lane_out == 3'b000, "R9 reset lanes", int'(lane_out), 0);
    chk(clk_lane == 1'b0, "R9 reset clock", int'(clk_lane), 0);
    rst = 1'b0; slot_en = 1'b0;
  endtask

  initial begin
    do_reset();
    phase_tag = "R7"; run(400, 100, 0);   // plain frames, dense enables
    phase_tag = "R7"; run(600, 100, 1);   // balanced frames
    phase_tag = "R8"; run(3000, 30, 1);   // sparse enables, balanced
    phase_tag = "R8"; run(2000, 45, 0);   // sparse enables, plain
    phase_tag = "R6"; run(6000, 70, 2);   // mode toggling at any time
    do_reset();
    phase_tag = "R9"; run(300, 100, 1);   // reset cut a frame short
    phase_tag = "R6"; run(4000, 50, 2);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule